// File: doc/BRIEF.md
# Radix-4 Booth Sequential Multiplier

This block multiplies two signed two's-complement operands of K bits and returns the full 2K-bit signed product. It retires two multiplier bits per clock by recoding overlapping groups of three multiplier bits into digits in the range -2 to +2. Each digit selects zero, the multiplicand, or twice the multiplicand, possibly inverted for subtraction. The three-times multiple is therefore never formed and no precompute cycle is spent.

The running upper partial product stays in redundant form as a sum vector and a carry vector. A row of full adders updates this pair each cycle, so no carry chain lies on the per-step path. The two lowest weights of each step are already final. A 3-bit adder fed by a single carry flop resolves them and shifts them into the low half of the product. After the last step, one carry-propagate addition merges the redundant pair into the upper half.

Software-free use is intended. A caller pulses `start` with both operands, waits for the one-cycle `done` pulse, and reads `product`. The product stays valid until the next operation completes.

Top module: `rb4_mul`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `done` is 0 and `product` is 0.
- R2: For any pair of K-bit two's-complement operands, `product` equals their signed product as a 2K-bit two's-complement value.
- R3: When `start` is sampled high by a clock edge E while the block is idle, `done` is high for exactly one cycle. That cycle follows edge E + K/2 + 1, and the new `product` is valid in the same cycle.
- R4: A `start` sampled while an operation is in its stepping phase is ignored. The running result is unaffected, and no extra `done` pulse appears.
- R5: `product` keeps its value from one `done` pulse until the next.
- R6: The most negative operand times itself yields the positive value 2^(2K-2), with no overflow.
- R7: The multiplier is scanned from the least significant end in bit triplets (upper, middle, lower), with an implicit 0 below bit 0. The triplets map to digits as follows: 000 and 111 give 0; 001 and 010 give +1; 011 gives +2; 100 gives -2; 101 and 110 give -1. Multipliers made only of long runs of ones, or of alternating bits, therefore give the correct product.
- R8: A zero operand on either side gives a zero product.
- R9: A `start` in the same cycle as `done` is accepted, so operations can run back to back with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation with the present operands when idle |
| multiplicand | input | K | Signed multiplicand |
| multiplier | input | K | Signed multiplier, recoded two bits per step |
| done | output | 1 | One-cycle pulse marking a fresh product |
| product | output | 2K | Signed 2K-bit product |

## Verification
A wrong recoded digit or a lost carry corrupts the redundant pair. That error stays hidden until the final merge. It then surfaces as a wrong upper half, or as wrong low bits if the damage sits in the two retired positions, exactly K/2 + 1 cycles after start. A miscounted step counter shows at once as `done` arriving early or late against the fixed latency. A control fault that lets a busy `start` reload the operands shows as the first result being replaced by the second one's value, or as a second `done` pulse.

// File: rtl/rb4_pkg.sv
package rb4_pkg;

   typedef struct packed {
      logic neg;
      logic two;
      logic non0;
   } rb4_digit_t;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIN  = 2'd2
   } rb4_state_e;

endpackage

// File: rtl/rb4_recode.sv
module rb4_recode
   import rb4_pkg::*;
(
   input  logic [2:0]  trip,
   output rb4_digit_t  dig
);
   logic run_edge_lo;
   logic run_edge_hi;

   always_comb begin
      run_edge_lo = trip[1] ^ trip[0];
      run_edge_hi = trip[2] ^ trip[1];
      dig.non0    = run_edge_lo | run_edge_hi;
      dig.two     = run_edge_hi & ~run_edge_lo;
      dig.neg     = trip[2] & dig.non0;
   end
endmodule

// File: rtl/rb4_multiple.sv
module rb4_multiple
   import rb4_pkg::*;
#(
   parameter int K = 16,
   parameter int W = 2 * K + 2
)(
   input  logic [K-1:0] a,
   input  rb4_digit_t   dig,
   output logic [W-1:0] mul,
   output logic         inj
);
   logic [W-1:0] ext;
   logic [W-1:0] base;

   always_comb begin
      ext  = {{(W - K){a[K-1]}}, a};
      base = dig.two ? {ext[W-2:0], 1'b0} : ext;
      if (!dig.non0)
         mul = '0;
      else if (dig.neg)
         mul = ~base;
      else
         mul = base;
      inj = dig.neg;
   end
endmodule

// File: rtl/rb4_csa.sv
module rb4_csa #(
   parameter int W = 34
)(
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   input  logic [W-1:0] z,
   input  logic         cin,
   output logic [W-1:0] s,
   output logic [W-1:0] c
);
   assign c[0] = cin;

   for (genvar i = 0; i < W; i++) begin : g_sum
      assign s[i] = x[i] ^ y[i] ^ z[i];
   end

   for (genvar i = 0; i < W - 1; i++) begin : g_carry
      assign c[i+1] = (x[i] & y[i]) | (x[i] & z[i]) | (y[i] & z[i]);
   end
endmodule

// File: rtl/rb4_mul.sv
module rb4_mul
   import rb4_pkg::*;
#(
   parameter int K = 16
)(
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [K-1:0]   multiplicand,
   input  logic [K-1:0]   multiplier,
   output logic           done,
   output logic [2*K-1:0] product
);
   localparam int STEPS = K / 2;
   localparam int W     = 2 * K + 2;
   localparam int CW    = (STEPS > 1) ? $clog2(STEPS) : 1;
   localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

   if ((K % 2) != 0 || K < 4) begin : g_bad_width
      $error("rb4_mul: K must be even and at least 4");
   end

   rb4_state_e     state;
   logic [CW-1:0]  cnt;
   logic [K-1:0]   mcand_q;
   logic [K:0]     mier_q;
   logic [W-1:0]   sum_q;
   logic [W-1:0]   car_q;
   logic           cr_q;
   logic [K-1:0]   lo_q;
   logic           done_q;
   logic [2*K-1:0] prod_q;

   rb4_digit_t     dig;
   logic [W-1:0]   mul_v;
   logic           inj;
   logic [W-1:0]   s_v;
   logic [W-1:0]   c_v;
   logic [2:0]     low_t;
   logic [K-1:0]   hi_v;

   rb4_recode u_recode (
      .trip (mier_q[2:0]),
      .dig  (dig)
   );

   rb4_multiple #(.K(K), .W(W)) u_multiple (
      .a   (mcand_q),
      .dig (dig),
      .mul (mul_v),
      .inj (inj)
   );

   rb4_csa #(.W(W)) u_csa (
      .x   (sum_q),
      .y   (car_q),
      .z   (mul_v),
      .cin (inj),
      .s   (s_v),
      .c   (c_v)
   );

   always_comb begin
      low_t = {1'b0, s_v[1:0]} + {1'b0, c_v[1:0]} + {2'b00, cr_q};
      hi_v  = sum_q[K-1:0] + car_q[K-1:0] + {{(K-1){1'b0}}, cr_q};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cnt     <= '0;
         mcand_q <= '0;
         mier_q  <= '0;
         sum_q   <= '0;
         car_q   <= '0;
         cr_q    <= 1'b0;
         lo_q    <= '0;
         done_q  <= 1'b0;
         prod_q  <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  mcand_q <= multiplicand;
                  mier_q  <= {multiplier, 1'b0};
                  sum_q   <= '0;
                  car_q   <= '0;
                  cr_q    <= 1'b0;
                  lo_q    <= '0;
                  cnt     <= '0;
                  state   <= ST_RUN;
               end
            end
            ST_RUN: begin
               sum_q  <= {2'b00, s_v[W-1:2]};
               car_q  <= {2'b00, c_v[W-1:2]};
               cr_q   <= low_t[2];
               lo_q   <= {low_t[1:0], lo_q[K-1:2]};
               mier_q <= {{2{mier_q[K]}}, mier_q[K:2]};
               if (cnt == LAST)
                  state <= ST_FIN;
               else
                  cnt <= cnt + 1'b1;
            end
            ST_FIN: begin
               prod_q <= {hi_v, lo_q};
               done_q <= 1'b1;
               state  <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign done    = done_q;
   assign product = prod_q;

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q); // R3

   AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RUN && start) |=> ($stable(mcand_q) && state != ST_IDLE)); // R4

   AST_PRODUCT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_FIN) |=> $stable(prod_q)); // R5

   AST_TWO_NEEDS_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      dig.two |-> dig.non0); // R7

   AST_ZERO_DIGIT_NO_MULT: assert property (@(posedge clk) disable iff (!rst_n)
      !dig.non0 |-> (mul_v == '0 && !inj)); // R7

endmodule

// File: tb/rb4_mul_bench.sv
module rb4_mul_bench;
   localparam int K     = 16;
   localparam int STEPS = K / 2;

   typedef struct {
      logic [2*K-1:0] exp;
      int             edge_no;
      string          tag;
   } item_t;

   logic           clk;
   logic           rst_n;
   logic           start;
   logic [K-1:0]   multiplicand;
   logic [K-1:0]   multiplier;
   logic           done;
   logic [2*K-1:0] product;

   int             cyc;
   int             n_tests;
   int             n_fail;
   logic           prev_done;
   logic [2*K-1:0] last_exp;
   item_t          sb[$];

   rb4_mul #(.K(K)) u_rb4_mul (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start),
      .multiplicand (multiplicand),
      .multiplier   (multiplier),
      .done         (done),
      .product      (product)
   );

   initial clk = 1'b0;
   always #2.5 clk = ~clk;

   initial cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [2*K-1:0] ref_mul(logic [K-1:0] a, logic [K-1:0] b);
      logic signed [2*K-1:0] ea;
      logic signed [2*K-1:0] eb;
      ea = {{K{a[K-1]}}, a};
      eb = {{K{b[K-1]}}, b};
      return ea * eb;
   endfunction

   task automatic check(input bit ok, input string tag, input logic [2*K-1:0] act,
                        input logic [2*K-1:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // driver: called at a negedge, pushes the expected item
   task automatic go(input logic [K-1:0] a, input logic [K-1:0] b, input string tag);
      item_t it;
      start        = 1'b1;
      multiplicand = a;
      multiplier   = b;
      it.exp       = ref_mul(a, b);
      it.edge_no   = cyc + 1;
      it.tag       = tag;
      sb.push_back(it);
      last_exp     = it.exp;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done();
      do @(negedge clk); while (!done);
   endtask

   task automatic run_one(input logic [K-1:0] a, input logic [K-1:0] b, input string tag);
      go(a, b, tag);
      wait_done();
      @(negedge clk);
   endtask

   // monitor: pops and compares on every done pulse
   initial prev_done = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (done && prev_done)
            check(1'b0, "R3 done longer than one cycle", 1, 0);
         if (done) begin
            if (sb.size() == 0) begin
               check(1'b0, "R4 unexpected done pulse", product, 0);
            end else begin
               item_t it;
               it = sb.pop_front();
               check(product == it.exp, {"R2 ", it.tag}, product, it.exp);
               check(cyc == it.edge_no + STEPS + 1, {"R3 latency ", it.tag},
                     2*K'(cyc), 2*K'(it.edge_no + STEPS + 1));
            end
         end
      end
      prev_done = done;
   end

   initial begin
      repeat (60000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [K-1:0] lfa;
      logic [K-1:0] lfb;
      n_tests      = 0;
      n_fail       = 0;
      start        = 1'b0;
      multiplicand = '0;
      multiplier   = '0;
      rst_n        = 1'b0;
      repeat (3) @(negedge clk);
      check(done == 1'b0, "R1 done in reset", 2*K'(done), 0);
      check(product == '0, "R1 product in reset", product, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(done == 1'b0 && product == '0, "R1 after reset", product, 0);

      // R2 small mixed-sign operands
      run_one(16'd3, 16'd5, "R2 3x5");
      run_one(-16'sd3, 16'd5, "R2 -3x5");
      run_one(16'd7, -16'sd9, "R2 7x-9");
      run_one(-16'sd1, -16'sd1, "R2 -1x-1");
      // R8 zero operands
      run_one(16'h0000, 16'h7abc, "R8 zero multiplicand");
      run_one(16'h8123, 16'h0000, "R8 zero multiplier");
      // R6 extremes
      run_one(16'h8000, 16'h8000, "R6 minxmin");
      check(last_exp == 32'h4000_0000, "R6 reference value", last_exp, 32'h4000_0000);
      run_one(16'h8000, 16'h7fff, "R6 minxmax");
      run_one(16'h7fff, 16'h7fff, "R6 maxxmax");
      // R7 recoding patterns
      run_one(16'h1234, 16'h5555, "R7 alternating 01");
      run_one(16'hbeef, 16'haaaa, "R7 alternating 10");
      run_one(16'h4321, 16'hffff, "R7 all ones");
      run_one(16'h0f0f, 16'h0ff0, "R7 runs of ones");
      run_one(16'hc001, 16'h0001, "R7 implicit zero below bit 0");

      // R2 pseudo-random operands
      lfa = 16'hace1;
      lfb = 16'h1357;
      for (int i = 0; i < 40; i++) begin
         lfa = {lfa[14:0], lfa[15] ^ lfa[13] ^ lfa[12] ^ lfa[10]};
         lfb = lfb * 16'd25173 + 16'd13849;
         run_one(lfa, lfb, "R2 pseudo-random");
      end

      // R4 start while busy is ignored
      go(16'd1234, -16'sd77, "R4 first operation");
      @(negedge clk);
      start        = 1'b1;
      multiplicand = 16'h7777;
      multiplier   = 16'h3333;
      @(negedge clk);
      start = 1'b0;
      wait_done();
      for (int i = 0; i < STEPS + 4; i++) begin
         @(negedge clk);
         check(done == 1'b0, "R4 no extra done", 2*K'(done), 0);
      end

      // R5 product holds
      check(product == last_exp, "R5 product held", product, last_exp);

      // R9 back-to-back
      go(16'd100, 16'd200, "R9 first");
      wait_done();
      go(-16'sd300, 16'd41, "R9 second in done cycle");
      wait_done();
      @(negedge clk);
      check(product == ref_mul(-16'sd300, 16'd41), "R9 back-to-back result",
            product, ref_mul(-16'sd300, 16'd41));
      repeat (4) @(negedge clk);
      check(product == last_exp, "R5 held after back-to-back", product, last_exp);
      check(sb.size() == 0, "R3 all results delivered", 2*K'(sb.size()), 0);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule